// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address. It walks a forward-mapped page table with two levels, held in a word-addressed table memory. A requester offers a virtual address and a load/store flag on a valid/ready handshake. The walker then makes two dependent reads:

- The first read fetches the directory entry, at the table-base input plus the upper index field.
- That entry gives the base of a leaf table. The second read fetches the leaf entry, at that base plus the lower index field.

A resident leaf gives a physical address: the leaf's frame number joined to the untouched page offset. A missing entry at either level ends the walk with a fault that names the level.

On a successful walk, one write-back to the leaf entry marks it as referenced. When the request is a store, the same write-back also marks it dirty.

The table memory sits outside the block. It has one synchronous port with one cycle of read latency, and it shares a single address bus between reads and writes. The walker keeps at most one access in flight. It takes no new request until the requester has consumed the previous result.

Top module: `pwk_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and neither `mem_rd_en` nor `mem_wr_en` is asserted while no request is offered.
- R2: The virtual address splits into the upper index `vaddr[19:15]`, the lower index `vaddr[14:10]` and the offset `vaddr[9:0]`. In the cycle a request is accepted, the walker reads the directory entry at `ptbr + vaddr[19:15]`.
- R3: Bit 15 of an entry is the resident flag, and bits 12:0 are a table base. For a resident directory entry, the next read goes to `entry[12:0] + vaddr[14:10]`. It is issued in the cycle the directory data returns.
- R4: For a resident leaf entry, the result is `{leaf[5:0], vaddr[9:0]}` with `rsp_fault` = 0 and `rsp_fault_lvl` = 0.
- R5: A non-resident directory entry ends the walk with `rsp_fault` = 1, `rsp_fault_lvl` = 1 and `rsp_paddr` = 0. No leaf read and no write are issued.
- R6: A non-resident leaf entry ends the walk with `rsp_fault` = 1, `rsp_fault_lvl` = 2 and `rsp_paddr` = 0. The table memory is left unchanged.
- R7: A successful walk writes the leaf entry back to its own address with bit 13 (reference) set. The response follows in the next cycle.
- R8: The write-back sets bit 14 (dirty) when `req_store` was 1. It leaves bit 14 as it was read when `req_store` was 0.
- R9: At most one table access occurs per cycle: a read and a write never coincide.
- R10: `rsp_valid` and its result stay stable until `rsp_ready` is seen. `req_ready` stays 0, and no table read starts, from acceptance until the response is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 20 | Virtual address to translate |
| req_store | input | 1 | Request is a store (sets dirty on success) |
| ptbr | input | 13 | Directory table base in table memory |
| mem_rd_en | output | 1 | Table read strobe; data returns next cycle |
| mem_wr_en | output | 1 | Table write strobe |
| mem_addr | output | 13 | Table word address for read or write |
| mem_wdata | output | 16 | Entry value to write |
| mem_rdata | input | 16 | Entry value returned by the read of the previous cycle |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester consumes the result |
| rsp_paddr | output | 16 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended on a non-resident entry |
| rsp_fault_lvl | output | 2 | Level of the missing entry: 0 none, 1 directory, 2 leaf |

## Verification
Two things can coincide: a finished result waiting on a stalled consumer, and a fresh request already held valid at the input. The bench leaves `rsp_ready` low for several cycles while a second request stays valid. During that time it requires `req_ready` to stay low, the pending result to stay unchanged, and the read count to stay flat. Once the result is consumed, the held request must be accepted on the following edge and translated correctly.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_L1 = 2'd1,
    ST_READ_L2 = 2'd2,
    ST_DONE    = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_L1   = 2'd1,
    FLT_L2   = 2'd2
  } fault_lvl_e;

  // flag positions counted down from the entry's top bit
  localparam int FLAG_RES_DN   = 0;
  localparam int FLAG_DIRTY_DN = 1;
  localparam int FLAG_REF_DN   = 2;
  localparam int FLAG_COUNT    = 3;
endpackage

// File: rtl/pwk_index.sv
module pwk_index #(
  parameter int OFF_W = 10,
  parameter int IDX_W = 5,
  parameter int TA_W  = 13,
  localparam int VA_W = OFF_W + 2 * IDX_W
) (
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [VA_W-1:0]  held_vaddr,
  input  logic [TA_W-1:0]  ptbr,
  input  logic [TA_W-1:0]  l2_base,
  output logic [TA_W-1:0]  l1_addr,
  output logic [TA_W-1:0]  l2_addr,
  output logic [OFF_W-1:0] offset
);
  function automatic logic [IDX_W-1:0] upper_idx(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] lower_idx(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TA_W-1:0] slot(input logic [TA_W-1:0] base,
                                           input logic [IDX_W-1:0] idx);
    return base + TA_W'(idx);
  endfunction

  assign l1_addr = slot(ptbr, upper_idx(req_vaddr));
  assign l2_addr = slot(l2_base, lower_idx(held_vaddr));
  assign offset  = held_vaddr[OFF_W-1:0];
endmodule

// File: rtl/pwk_ctrl.sv
module pwk_ctrl
  import pwk_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int IDX_W = 5,
  parameter int TA_W  = 13,
  parameter int PA_W  = 16,
  parameter int ENT_W = 16,
  localparam int VA_W    = OFF_W + 2 * IDX_W,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic [VA_W-1:0]  held_vaddr,
  input  logic [TA_W-1:0]  l1_addr,
  input  logic [TA_W-1:0]  l2_addr,
  input  logic [OFF_W-1:0] offset,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [TA_W-1:0]  mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault_lvl
);
  function automatic logic is_resident(input logic [ENT_W-1:0] e);
    return e[ENT_W-1-FLAG_RES_DN];
  endfunction

  function automatic logic [ENT_W-1:0] mark_used(input logic [ENT_W-1:0] e,
                                                 input logic store);
    logic [ENT_W-1:0] r;
    r = e;
    r[ENT_W-1-FLAG_REF_DN] = 1'b1;
    if (store) r[ENT_W-1-FLAG_DIRTY_DN] = 1'b1;
    return r;
  endfunction

  walk_state_e      state_q, state_d;
  logic             store_q;
  logic [TA_W-1:0]  leaf_addr_q;
  logic [PA_W-1:0]  paddr_q;
  fault_lvl_e       lvl_q;
  logic             hit;

  assign hit = is_resident(mem_rdata);

  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          mem_rd_en = 1'b1;
          mem_addr  = l1_addr;
          state_d   = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        state_d = ST_DONE;
        if (hit) begin
          mem_rd_en = 1'b1;
          mem_addr  = l2_addr;
          state_d   = ST_READ_L2;
        end
      end
      ST_READ_L2: begin
        state_d = ST_DONE;
        if (hit) begin
          mem_wr_en = 1'b1;
          mem_addr  = leaf_addr_q;
          mem_wdata = mark_used(mem_rdata, store_q);
        end
      end
      default: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      held_vaddr  <= '0;
      store_q     <= 1'b0;
      leaf_addr_q <= '0;
      paddr_q     <= '0;
      lvl_q       <= FLT_NONE;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          held_vaddr <= req_vaddr;
          store_q    <= req_store;
        end
        ST_READ_L1: begin
          leaf_addr_q <= l2_addr;
          if (!hit) begin
            lvl_q   <= FLT_L1;
            paddr_q <= '0;
          end
        end
        ST_READ_L2: begin
          if (hit) begin
            lvl_q   <= FLT_NONE;
            paddr_q <= {mem_rdata[FRAME_W-1:0], offset};
          end else begin
            lvl_q   <= FLT_L2;
            paddr_q <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault_lvl = lvl_q;
endmodule

// File: rtl/pwk_walker.sv
module pwk_walker
  import pwk_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int IDX_W = 5,
  parameter int TA_W  = 13,
  parameter int PA_W  = 16,
  parameter int ENT_W = 16,
  localparam int VA_W = OFF_W + 2 * IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic [TA_W-1:0]  ptbr,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [TA_W-1:0]  mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_fault_lvl
);
  logic [VA_W-1:0]  held_vaddr;
  logic [TA_W-1:0]  l1_addr, l2_addr;
  logic [OFF_W-1:0] offset;
  logic             ev_accept;

  assign ev_accept = req_valid & req_ready;

  pwk_index #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TA_W(TA_W)) u_index (
    .req_vaddr (req_vaddr),
    .held_vaddr(held_vaddr),
    .ptbr      (ptbr),
    .l2_base   (mem_rdata[TA_W-1:0]),
    .l1_addr   (l1_addr),
    .l2_addr   (l2_addr),
    .offset    (offset)
  );

  pwk_ctrl #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TA_W(TA_W), .PA_W(PA_W),
             .ENT_W(ENT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_vaddr    (req_vaddr),
    .req_ready    (req_ready),
    .held_vaddr   (held_vaddr),
    .l1_addr      (l1_addr),
    .l2_addr      (l2_addr),
    .offset       (offset),
    .mem_rdata    (mem_rdata),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault_lvl(rsp_fault_lvl)
  );

  assign rsp_fault = (rsp_fault_lvl != FLT_NONE);
endmodule

// File: rtl/pwk_walker_chk.sv
module pwk_walker_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_accept,
  input logic            req_ready,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic            wb_res,
  input logic            wb_ref,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic [1:0]      rsp_fault_lvl
);
  p_accept_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> mem_rd_en);

  p_fault_no_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_fault_lvl != 2'd0));

  p_wb_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (wb_res && wb_ref));

  p_wb_then_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (rsp_valid && !rsp_fault));

  p_one_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault_lvl)));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && !mem_rd_en));
endmodule

bind pwk_walker pwk_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_accept    (ev_accept),
  .req_ready    (req_ready),
  .mem_rd_en    (mem_rd_en),
  .mem_wr_en    (mem_wr_en),
  .wb_res       (mem_wdata[ENT_W-1]),
  .wb_ref       (mem_wdata[ENT_W-3]),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .rsp_fault_lvl(rsp_fault_lvl)
);

// File: tb/tb_pwk_walker.sv
`timescale 1ns/1ps
module tb_pwk_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic [12:0] ptbr = '0;
  logic        mem_rd_en, mem_wr_en;
  logic [12:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_fault_lvl;

  always #2 clk = ~clk;

  pwk_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .ptbr(ptbr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl)
  );

  // table memory model: one port, one cycle read latency
  logic [15:0] tmem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_addr = '0;
  logic [15:0] poke_data = '0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [12:0] rd_log [8];

  always @(posedge clk) begin
    if (poke_en) tmem[poke_addr] <= poke_data;
    if (mem_rd_en) begin
      mem_rdata <= tmem[mem_addr[7:0]];
      rd_log[rd_cnt % 8] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr_en) begin
      tmem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  int tests_run = 0;
  int tests_failed = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic issue(input logic [19:0] va, input logic st);
    @(negedge clk);
    req_vaddr = va; req_store = st; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, tag, 32'(rsp_valid), 32'd1);
  endtask

  task automatic consume();
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic walk_hit(input string tag, input logic [19:0] va, input logic st,
                          input logic [7:0] l1a, input logic [7:0] l2a,
                          input logic [15:0] exp_pa, input logic [15:0] exp_leaf);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    issue(va, st);
    wait_rsp(tag);
    chk(rsp_paddr == exp_pa && !rsp_fault && rsp_fault_lvl == 2'd0,
        {tag, " R4 paddr"}, {rsp_fault_lvl, rsp_fault, 13'd0, rsp_paddr}, {16'd0, exp_pa});
    chk(rd_cnt - r0 == 2 && rd_log[r0 % 8] == 13'(l1a), {tag, " R2 directory addr"},
        32'(rd_log[r0 % 8]), 32'(l1a));
    chk(rd_log[(r0 + 1) % 8] == 13'(l2a), {tag, " R3 leaf addr"},
        32'(rd_log[(r0 + 1) % 8]), 32'(l2a));
    chk(wr_cnt - w0 == 1 && tmem[l2a] == exp_leaf, {tag, " R7/R8 write-back"},
        32'(tmem[l2a]), 32'(exp_leaf));
    consume();
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en && !mem_wr_en, "R1 reset state",
        {28'd0, req_ready, rsp_valid, mem_rd_en, mem_wr_en}, 32'h8);
  endtask

  // R5
  task automatic t_l1_fault();
    int r0, w0;
    ptbr = 13'h10;
    poke(8'h16, 16'h4080);
    r0 = rd_cnt; w0 = wr_cnt;
    issue(20'h30123, 1'b1);
    wait_rsp("R5 response");
    chk(rsp_fault && rsp_fault_lvl == 2'd1 && rsp_paddr == 16'h0, "R5 level-1 fault",
        {rsp_fault_lvl, rsp_fault, 13'd0, rsp_paddr}, {2'd1, 1'b1, 29'd0});
    chk(rd_cnt - r0 == 1 && wr_cnt == w0 && tmem[8'h16] == 16'h4080,
        "R5 no leaf read or write", 32'(rd_cnt - r0), 32'd1);
    consume();
  endtask

  // R6
  task automatic t_l2_fault();
    int r0, w0;
    poke(8'h17, 16'h8090);
    poke(8'h99, 16'h203F);
    r0 = rd_cnt; w0 = wr_cnt;
    issue(20'h3A402, 1'b1);
    wait_rsp("R6 response");
    chk(rsp_fault && rsp_fault_lvl == 2'd2 && rsp_paddr == 16'h0, "R6 level-2 fault",
        {rsp_fault_lvl, rsp_fault, 13'd0, rsp_paddr}, {2'd2, 1'b1, 29'd0});
    chk(rd_cnt - r0 == 2 && wr_cnt == w0 && tmem[8'h99] == 16'h203F,
        "R6 leaf unchanged", 32'(tmem[8'h99]), 32'h203F);
    consume();
  endtask

  // R10: stalled consumer while a new request waits
  task automatic t_backpressure();
    logic [15:0] held;
    int r0;
    ptbr = 13'h10;
    issue(20'h19D55, 1'b0);
    wait_rsp("R10 first response");
    held = rsp_paddr;
    r0 = rd_cnt;
    req_vaddr = 20'h20BA0; req_store = 1'b1; req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!req_ready && rsp_valid && rsp_paddr == held && rd_cnt == r0,
          "R10 hold under stall", {15'd0, req_ready, rsp_paddr}, {16'd0, held});
    end
    chk(held == 16'hA955, "R10 first result", 32'(held), 32'hA955);
    consume();
    @(negedge clk);
    chk(req_ready, "R10 ready after consume", 32'(req_ready), 32'd1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    wait_rsp("R10 second response");
    chk(rsp_paddr == 16'h47A0 && !rsp_fault, "R10 held request translated",
        32'(rsp_paddr), 32'h47A0);
    consume();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      poke_en = 1'b1; poke_addr = 8'(i); poke_data = 16'h0;
    end
    @(negedge clk);
    poke_en = 1'b0;
    rst_n = 1'b1;
    t_reset();

    // load hit: p1=3 p2=7 off=0x155
    ptbr = 13'h10;
    poke(8'h13, 16'h8040);
    poke(8'h47, 16'h802A);
    walk_hit("R4 load hit", 20'h19D55, 1'b0, 8'h13, 8'h47, 16'hA955, 16'hA02A);

    // store hit sets dirty: p1=4 p2=2 off=0x3A0
    poke(8'h14, 16'h8060);
    poke(8'h62, 16'h8011);
    walk_hit("R8 store dirty", 20'h20BA0, 1'b1, 8'h14, 8'h62, 16'h47A0, 16'hE011);

    // load keeps an already-set dirty bit: p1=5 p2=1 off=0
    poke(8'h15, 16'h8070);
    poke(8'h71, 16'hC005);
    walk_hit("R8 load keeps dirty", 20'h28400, 1'b0, 8'h15, 8'h71, 16'h1400, 16'hE005);

    t_l1_fault();
    t_l2_fault();

    // all-ones indices and offset
    ptbr = 13'hE0;
    poke(8'hFF, 16'h80C0);
    poke(8'hDF, 16'h803F);
    walk_hit("R3 max index", 20'hFFFFF, 1'b0, 8'hFF, 8'hDF, 16'hFFFF, 16'hA03F);

    t_backpressure();

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule